// File: doc/BRIEF.md
# Predicated Operation Squash Unit

This block sits between the decode stage and the execution slots of a wide-issue machine in which every bundle holds several operations that issue in parallel. It keeps a small file of one-bit predicates. Each slot names the predicate that guards it. When that predicate reads false, the block marks the slot as killed and holds its register write enable low, so the operation retires as a no-op. Operations that must always run name predicate 0, which always reads true.

Compare operations carried in the bundle update the predicate file. Each compare has a guard of its own and two target predicates. When the guard is true, the first target receives the compare outcome and the second receives its inverse. A slot may also be a conditional move. Such a slot tests a general register value for zero or for non-zero, and it writes back only when the test passes. Updates to the predicate file reach the guards of the following bundle. The present bundle still reads the old values. This lets a pair of complementary predicates steer the two arms of an if/else through separate slots of a single later bundle.

Top module: `pred_squash_unit`

## Requirements
- R1: After a synchronous active-low reset, predicates 1 to 7 read false, so any slot guarded by one of them is killed.
- R2: Predicate 0 always reads true. A compare that targets index 0 leaves it true, and a slot guarded by index 0 is never killed.
- R3: `slot_kill[s]` is high in the same cycle exactly when the predicate named by slot s's 3-bit field `slot_guard_idx[3s+2:3s]` is false. This holds whatever the slot's write and move inputs are.
- R4: `slot_wen_out[s]` is low whenever slot s is killed or `bundle_valid` is low. For a slot that is not a conditional move, it otherwise equals `slot_wen_in[s]`.
- R5: In a cycle where `bundle_valid` is high, `cmp_valid[c]` is high and compare c's guard predicate is true, the next clock edge loads `cmp_result[c]` into the predicate named by `cmp_dst_true` and its inverse into the predicate named by `cmp_dst_false`. The new values affect the kills only from the following cycle.
- R6: A compare writes no predicate when `bundle_valid` is low, when its `cmp_valid` bit is low, or when its own guard predicate is false.
- R7: A slot with `slot_cmov_en` high and `slot_cmov_sense` = 0 (move on zero) asserts its write enable only if its 32-bit `slot_rt_val` field equals zero, the slot is not killed, the bundle is valid and `slot_wen_in` is high.
- R8: A slot with `slot_cmov_en` high and `slot_cmov_sense` = 1 (move on non-zero) asserts its write enable only if its `slot_rt_val` field is not zero, under the same other conditions as R7.
- R9: When writes in one bundle collide on one predicate, the compare with the higher index wins. Within one compare that names the same predicate twice, the true target wins, so that predicate takes `cmp_result`.
- R10: After one compare writes a complementary pair with distinct nonzero targets, two slots of a single bundle guarded by those two predicates are never both killed and never both live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bundle_valid | input | 1 | The current bundle issues this cycle |
| slot_guard_idx | input | 18 | Guard predicate index per slot, 3 bits each, slot 0 in the low bits |
| slot_wen_in | input | 6 | Register write request per slot |
| slot_cmov_en | input | 6 | Slot is a conditional move |
| slot_cmov_sense | input | 6 | 0 = move on zero, 1 = move on non-zero |
| slot_rt_val | input | 192 | 32-bit tested register value per slot |
| cmp_valid | input | 2 | Compare c is present in the bundle |
| cmp_result | input | 2 | Outcome of compare c |
| cmp_guard_idx | input | 6 | Guard predicate index per compare |
| cmp_dst_true | input | 6 | Target receiving the outcome, per compare |
| cmp_dst_false | input | 6 | Target receiving the inverse, per compare |
| slot_kill | output | 6 | Slot squashed to a no-op |
| slot_wen_out | output | 6 | Gated register write enable per slot |

## Verification
Two functions can fall in the same cycle. In one, a compare rewrites a predicate. In the other, a slot in the same bundle reads that predicate as its guard. The bench provokes this by guarding a slot with the very predicate that a compare targets in the same bundle. It expects the old value in that cycle and the new one in the next. The random phase produces many more such overlaps, together with compares whose own guards were written one bundle earlier. Every output is judged against a bench model that updates its predicates only after the clock edge.

// File: rtl/pred_pkg.sv
// Shared types of the predicated squash unit.
// Assumes: nothing beyond the standard language.
package pred_pkg;

    // Sense of a conditional-move test on the tested register.
    typedef enum logic {
        MOVE_ON_ZERO    = 1'b0,
        MOVE_ON_NONZERO = 1'b1
    } cmov_sense_e;

endpackage

// File: rtl/pred_cmp_decode.sv
// Turns the compares of one bundle into per-predicate write enables and values.
// Assumes: NUM_PREDS is a power of two, so every index is in range. Guards are
// read from the current (old) predicate state. A later compare overrides an
// earlier one, and a true target overrides a false target. Index 0 is never written.
module pred_cmp_decode #(
    parameter int NUM_PREDS = 8,
    parameter int NUM_CMP   = 2,
    localparam int IDX_W    = $clog2(NUM_PREDS)
) (
    input  logic                       bundle_valid,
    input  logic [NUM_PREDS-1:0]       pred_vec,
    input  logic [NUM_CMP-1:0]         cmp_valid,
    input  logic [NUM_CMP-1:0]         cmp_result,
    input  logic [NUM_CMP*IDX_W-1:0]   cmp_guard_idx,
    input  logic [NUM_CMP*IDX_W-1:0]   cmp_dst_true,
    input  logic [NUM_CMP*IDX_W-1:0]   cmp_dst_false,
    output logic [NUM_PREDS-1:0]       wr_en,
    output logic [NUM_PREDS-1:0]       wr_val
);

    // Merge all compare writes in priority order into one write request per predicate.
    always_comb begin
        wr_en  = '0;
        wr_val = '0;
        for (int c = 0; c < NUM_CMP; c++) begin
            if (bundle_valid && cmp_valid[c] &&
                pred_vec[cmp_guard_idx[c*IDX_W +: IDX_W]]) begin
                wr_en [cmp_dst_false[c*IDX_W +: IDX_W]] = 1'b1;
                wr_val[cmp_dst_false[c*IDX_W +: IDX_W]] = ~cmp_result[c];
                wr_en [cmp_dst_true[c*IDX_W +: IDX_W]]  = 1'b1;
                wr_val[cmp_dst_true[c*IDX_W +: IDX_W]]  = cmp_result[c];
            end
        end
        wr_en[0]  = 1'b0;
        wr_val[0] = 1'b0;
    end

endmodule

// File: rtl/pred_regfile.sv
// Predicate register file. Entry 0 is a constant true; the others are stored flops.
// Assumes: wr_en/wr_val come from a decoder that has already resolved priority.
module pred_regfile #(
    parameter int NUM_PREDS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PREDS-1:0] wr_en,
    input  logic [NUM_PREDS-1:0] wr_val,
    output logic [NUM_PREDS-1:0] pred_vec
);

    logic [NUM_PREDS-1:1] pred_q;

    // Clear the stored predicates on reset, otherwise load the ones being written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '0;
        end else begin
            for (int k = 1; k < NUM_PREDS; k++) begin
                if (wr_en[k]) pred_q[k] <= wr_val[k];
            end
        end
    end

    // Present the full read vector with entry 0 tied true.
    always_comb begin
        pred_vec = {pred_q, 1'b1};
    end

    // R2: the decoder must never hand a write to the constant entry.
    assert_p0_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        {wr_en[0], wr_val[0]} == 2'b00);

    for (genvar k = 1; k < NUM_PREDS; k++) begin : g_chk
        // R5: a requested write shows up on the read port one cycle later.
        assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[k] |=> (pred_vec[k] == $past(wr_val[k])));
        // R6: a predicate without a write request keeps its value.
        assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[k] |=> $stable(pred_vec[k]));
    end

endmodule

// File: rtl/pred_slot_squash.sv
// Per-slot squash logic: reads the guard predicate, raises kill when it is false,
// and gates the register write with bundle valid, the guard and the move test.
// Assumes: pred_vec already reflects all writes from earlier bundles only.
module pred_slot_squash #(
    parameter int NUM_PREDS = 8,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_PREDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bundle_valid,
    input  logic [NUM_PREDS-1:0] pred_vec,
    input  logic [IDX_W-1:0]     guard_idx,
    input  logic                 wen_in,
    input  logic                 cmov_en,
    input  logic                 cmov_sense,
    input  logic [DATA_W-1:0]    rt_val,
    output logic                 kill,
    output logic                 wen_out
);
    import pred_pkg::*;

    cmov_sense_e sense;
    logic        rt_zero;
    logic        move_ok;

    // Evaluate the conditional-move test for this slot.
    always_comb begin
        sense   = cmov_sense_e'(cmov_sense);
        rt_zero = (rt_val == '0);
        if (!cmov_en)                  move_ok = 1'b1;
        else if (sense == MOVE_ON_ZERO) move_ok = rt_zero;
        else                           move_ok = !rt_zero;
    end

    // Squash on a false guard and gate the write enable.
    always_comb begin
        kill    = !pred_vec[guard_idx];
        wen_out = bundle_valid && wen_in && !kill && move_ok;
    end

    // R7: a move-on-zero only writes when the tested register is zero.
    assert_cmovz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_out && cmov_en && !cmov_sense) |-> (rt_val == '0));
    // R8: a move-on-non-zero only writes when the tested register is non-zero.
    assert_cmovnz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wen_out && cmov_en && cmov_sense) |-> (rt_val != '0));

endmodule

// File: rtl/pred_squash_unit.sv
// Top of the predicated squash unit: predicate file, compare decoder and one
// squash instance per issue slot.
// Assumes: compares and slots of one bundle arrive together with bundle_valid;
// the outputs are combinational from the inputs and the stored predicates.
module pred_squash_unit #(
    parameter int NUM_PREDS = 8,
    parameter int NUM_SLOTS = 6,
    parameter int NUM_CMP   = 2,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_PREDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bundle_valid,
    input  logic [NUM_SLOTS*IDX_W-1:0]  slot_guard_idx,
    input  logic [NUM_SLOTS-1:0]        slot_wen_in,
    input  logic [NUM_SLOTS-1:0]        slot_cmov_en,
    input  logic [NUM_SLOTS-1:0]        slot_cmov_sense,
    input  logic [NUM_SLOTS*DATA_W-1:0] slot_rt_val,
    input  logic [NUM_CMP-1:0]          cmp_valid,
    input  logic [NUM_CMP-1:0]          cmp_result,
    input  logic [NUM_CMP*IDX_W-1:0]    cmp_guard_idx,
    input  logic [NUM_CMP*IDX_W-1:0]    cmp_dst_true,
    input  logic [NUM_CMP*IDX_W-1:0]    cmp_dst_false,
    output logic [NUM_SLOTS-1:0]        slot_kill,
    output logic [NUM_SLOTS-1:0]        slot_wen_out
);

    logic [NUM_PREDS-1:0] pred_vec;
    logic [NUM_PREDS-1:0] wr_en;
    logic [NUM_PREDS-1:0] wr_val;

    pred_cmp_decode #(.NUM_PREDS(NUM_PREDS), .NUM_CMP(NUM_CMP)) u_decode (
        .bundle_valid  (bundle_valid),
        .pred_vec      (pred_vec),
        .cmp_valid     (cmp_valid),
        .cmp_result    (cmp_result),
        .cmp_guard_idx (cmp_guard_idx),
        .cmp_dst_true  (cmp_dst_true),
        .cmp_dst_false (cmp_dst_false),
        .wr_en         (wr_en),
        .wr_val        (wr_val)
    );

    pred_regfile #(.NUM_PREDS(NUM_PREDS)) u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_val   (wr_val),
        .pred_vec (pred_vec)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        pred_slot_squash #(.NUM_PREDS(NUM_PREDS), .DATA_W(DATA_W)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .bundle_valid (bundle_valid),
            .pred_vec     (pred_vec),
            .guard_idx    (slot_guard_idx[s*IDX_W +: IDX_W]),
            .wen_in       (slot_wen_in[s]),
            .cmov_en      (slot_cmov_en[s]),
            .cmov_sense   (slot_cmov_sense[s]),
            .rt_val       (slot_rt_val[s*DATA_W +: DATA_W]),
            .kill         (slot_kill[s]),
            .wen_out      (slot_wen_out[s])
        );
    end

    // R4: no slot may write while it is squashed or while no bundle issues.
    assert_killed_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_wen_out & slot_kill) == '0) && (bundle_valid || slot_wen_out == '0));

endmodule

// File: tb/test_pred_squash_unit.sv
module test_pred_squash_unit;

    localparam int NP = 8;
    localparam int NS = 6;
    localparam int NC = 2;
    localparam int DW = 32;
    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            bundle_valid;
    logic [NS*IW-1:0] slot_guard_idx;
    logic [NS-1:0]   slot_wen_in, slot_cmov_en, slot_cmov_sense;
    logic [NS*DW-1:0] slot_rt_val;
    logic [NC-1:0]   cmp_valid, cmp_result;
    logic [NC*IW-1:0] cmp_guard_idx, cmp_dst_true, cmp_dst_false;
    logic [NS-1:0]   slot_kill, slot_wen_out;

    int total = 0;
    int bad   = 0;
    logic m_pred [NP];

    always #5 clk = ~clk;

    pred_squash_unit i_pred_squash_unit (
        .clk(clk), .rst_n(rst_n), .bundle_valid(bundle_valid),
        .slot_guard_idx(slot_guard_idx), .slot_wen_in(slot_wen_in),
        .slot_cmov_en(slot_cmov_en), .slot_cmov_sense(slot_cmov_sense),
        .slot_rt_val(slot_rt_val), .cmp_valid(cmp_valid), .cmp_result(cmp_result),
        .cmp_guard_idx(cmp_guard_idx), .cmp_dst_true(cmp_dst_true),
        .cmp_dst_false(cmp_dst_false), .slot_kill(slot_kill), .slot_wen_out(slot_wen_out)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clear_inputs();
        bundle_valid = 1'b0; slot_guard_idx = '0; slot_wen_in = '0;
        slot_cmov_en = '0; slot_cmov_sense = '0; slot_rt_val = '0;
        cmp_valid = '0; cmp_result = '0; cmp_guard_idx = '0;
        cmp_dst_true = '0; cmp_dst_false = '0;
    endtask

    function automatic logic exp_wen(input int s);
        logic g, ok;
        logic [DW-1:0] rt;
        g  = m_pred[int'(slot_guard_idx[s*IW +: IW])];
        rt = slot_rt_val[s*DW +: DW];
        if (!slot_cmov_en[s]) ok = 1'b1;
        else if (slot_cmov_sense[s]) ok = (rt != 0);
        else ok = (rt == 0);
        return bundle_valid && slot_wen_in[s] && g && ok;
    endfunction

    // Check every slot against the model, then advance the model across the edge.
    task automatic run_bundle();
        logic nx [NP];
        #1;
        for (int s = 0; s < NS; s++) begin
            string wtag;
            check("R3 kill", slot_kill[s], !m_pred[int'(slot_guard_idx[s*IW +: IW])]);
            wtag = !slot_cmov_en[s] ? "R4 wen" : (slot_cmov_sense[s] ? "R8 cmovnz" : "R7 cmovz");
            check(wtag, slot_wen_out[s], exp_wen(s));
        end
        for (int k = 0; k < NP; k++) nx[k] = m_pred[k];
        for (int c = 0; c < NC; c++) begin
            if (bundle_valid && cmp_valid[c] && m_pred[int'(cmp_guard_idx[c*IW +: IW])]) begin
                nx[int'(cmp_dst_false[c*IW +: IW])] = !cmp_result[c];
                nx[int'(cmp_dst_true[c*IW +: IW])]  = cmp_result[c];
            end
        end
        nx[0] = 1'b1;
        @(posedge clk);
        for (int k = 0; k < NP; k++) m_pred[k] = nx[k];
    endtask

    // Read one predicate through slot 0's kill output without writing anything.
    task automatic probe(input int idx, input logic exp_true, input string tag);
        @(negedge clk);
        clear_inputs();
        slot_guard_idx[0 +: IW] = IW'(idx);
        #1;
        check(tag, !slot_kill[0], exp_true);
    endtask

    task automatic set_cmp(input int c, input int g, input int t, input int f, input logic r);
        cmp_valid[c] = 1'b1; cmp_result[c] = r;
        cmp_guard_idx[c*IW +: IW] = IW'(g);
        cmp_dst_true[c*IW +: IW]  = IW'(t);
        cmp_dst_false[c*IW +: IW] = IW'(f);
    endtask

    initial begin
        #(200000 * 10);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'd4242);
        for (int k = 0; k < NP; k++) m_pred[k] = (k == 0);
        clear_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 / R2: reset state.
        for (int k = 1; k < NP; k++) probe(k, 1'b0, "R1 reset");
        probe(0, 1'b1, "R2 p0 true");

        // R5: pair write, invisible this bundle, visible next.
        @(negedge clk); clear_inputs();
        bundle_valid = 1'b1; set_cmp(0, 0, 3, 4, 1'b1);
        slot_guard_idx[0 +: IW] = 3'd3;
        #1; check("R5 same cycle old", slot_kill[0], 1'b1);
        run_bundle();
        probe(3, 1'b1, "R5 true target");
        probe(4, 1'b0, "R5 false target");

        // R10: complementary guards in one bundle.
        @(negedge clk); clear_inputs();
        slot_guard_idx[0 +: IW] = 3'd3; slot_guard_idx[IW +: IW] = 3'd4;
        #1; check("R10 pair", slot_kill[0] ^ slot_kill[1], 1'b1);
        @(negedge clk); bundle_valid = 1'b1; cmp_valid = '0; set_cmp(1, 0, 3, 4, 1'b0);
        run_bundle();
        @(negedge clk); clear_inputs();
        slot_guard_idx[0 +: IW] = 3'd3; slot_guard_idx[IW +: IW] = 3'd4;
        #1; check("R10 flipped", slot_kill[0] ^ slot_kill[1], 1'b1);
        check("R10 flipped p3", slot_kill[0], 1'b1);

        // R2: compare targeting index 0.
        @(negedge clk); clear_inputs(); bundle_valid = 1'b1; set_cmp(0, 0, 0, 5, 1'b0);
        run_bundle();
        probe(0, 1'b1, "R2 write to p0 ignored");
        probe(5, 1'b1, "R2 partner written");

        // R6: false guard, invalid bundle, invalid compare.
        @(negedge clk); clear_inputs(); bundle_valid = 1'b1; set_cmp(0, 3, 6, 7, 1'b1);
        run_bundle();
        probe(6, 1'b0, "R6 false guard");
        @(negedge clk); clear_inputs(); set_cmp(0, 0, 6, 7, 1'b1);
        run_bundle();
        probe(6, 1'b0, "R6 bundle invalid");
        @(negedge clk); clear_inputs(); bundle_valid = 1'b1; set_cmp(0, 0, 6, 7, 1'b1);
        cmp_valid = '0;
        run_bundle();
        probe(6, 1'b0, "R6 compare invalid");

        // R9: collisions.
        @(negedge clk); clear_inputs(); bundle_valid = 1'b1;
        set_cmp(0, 0, 2, 6, 1'b1); set_cmp(1, 0, 7, 2, 1'b1);
        run_bundle();
        probe(2, 1'b0, "R9 higher compare wins");
        @(negedge clk); clear_inputs(); bundle_valid = 1'b1; set_cmp(0, 0, 1, 1, 1'b1);
        run_bundle();
        probe(1, 1'b1, "R9 true target wins");

        // R7 / R8 / R4: conditional moves and invalid bundle.
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); clear_inputs(); bundle_valid = 1'b1;
            slot_wen_in[2] = 1'b1; slot_cmov_en[2] = 1'b1;
            slot_cmov_sense[2] = v[1];
            slot_rt_val[2*DW +: DW] = v[0] ? 32'h0000_0100 : 32'h0;
            #1;
            check(v[1] ? "R8 cmovnz" : "R7 cmovz", slot_wen_out[2], v[1] ~^ v[0]);
        end
        @(negedge clk); clear_inputs(); slot_wen_in = '1;
        #1; check("R4 no bundle", |slot_wen_out, 1'b0);

        // Random phase.
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            r = $urandom; bundle_valid = (r[2:0] != 0);
            for (int s = 0; s < NS; s++) begin
                r = $urandom;
                slot_guard_idx[s*IW +: IW] = r[2:0];
                slot_wen_in[s] = r[3]; slot_cmov_en[s] = (r[5:4] == 0);
                slot_cmov_sense[s] = r[6];
                slot_rt_val[s*DW +: DW] = r[7] ? 32'h0 : $urandom;
            end
            for (int c = 0; c < NC; c++) begin
                r = $urandom;
                cmp_valid[c] = r[0]; cmp_result[c] = r[1];
                cmp_guard_idx[c*IW +: IW] = r[3] ? 3'd0 : r[6:4];
                cmp_dst_true[c*IW +: IW]  = r[9:7];
                cmp_dst_false[c*IW +: IW] = r[12:10];
            end
            run_bundle();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule